// File: doc/BRIEF.md
# Mode-Controlled GPIO Port Data Register

This block is a seven-pin general-purpose I/O port on a simple CPU register bus. Each pin has a two-bit mode, held in a 16-bit mode register. The mode picks one of four uses for the pin: an alternate peripheral function, a push-pull output, an input with pull-up, or an input without pull-up. An 8-bit data register holds one latch bit per pin. Writes always store the value. The pad only sees the stored value when the pin is in output mode.

On a data-register read, each bit comes from one of two places, chosen by that pin's mode. Alternate and output modes return the stored latch. The two input modes return the pin level after a two-flop synchronizer. The block drives three signals per pin to the pad: output enable, output data and pull-up enable.

Power-on reset clears the data latches and puts every pin in input-with-pull-up mode. Manual reset does not change either register. While manual reset is held, the bus is blocked and the read-data register is cleared. Standby and sleep need no handling here: with no writes, the registers simply keep their contents.

Top module: `gpio_mode_port`

## Requirements
- R1: One cycle of `por_n` low, sampled at a clock edge, sets every data latch to 0 and every mode field to 10. The mode register then reads 0x2AAA, `pin_pu` is 0x7F, and `pin_oe` and `pin_out` are 0.
- R2: Data-register bit 7 always reads 0, and writes to it are ignored. Mode-register bits 15:14 always read 0, and writes to them are ignored. Bits above 7 of a data read are 0.
- R3: The mode of pin n is in mode-register bits [2n+1:2n]. In mode 01 (output), `pin_oe[n]` is 1 and `pin_out[n]` equals latch bit n. In every other mode, `pin_oe[n]` and `pin_out[n]` are 0.
- R4: `pin_pu[n]` is 1 only in mode 10. Modes 00 and 11 drive both `pin_pu[n]` and `pin_oe[n]` to 0.
- R5: In modes 00 and 01, data-read bit n returns the stored latch bit n.
- R6: In modes 10 and 11, data-read bit n returns `pin_in[n]` after two synchronizer flops. A read sampled at the first or second edge after a pin change returns the old level. A read sampled at the third edge returns the new level.
- R7: A data write updates the latches in every mode, including the input modes, where the write has no effect on the pad.
- R8: While `mrst_n` is low, the data and mode registers keep their contents, bus writes are ignored, and `bus_rdata` is cleared to 0.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is sampled high, so it is valid one cycle after the strobe. Otherwise it holds its value.
- R10: A write takes effect at the edge where `bus_wr` is sampled. A read strobed in the next cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| bus_sel | input | 1 | Register select: 0 selects the data register, 1 selects the mode register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 7 | Pad input levels (asynchronous) |
| pin_out | output | 7 | Pad output data |
| pin_oe | output | 7 | Pad output enable |
| pin_pu | output | 7 | Pad pull-up enable |

## Verification
The bench runs the read path with all seven pins in each of the four uniform modes. In each case the latch and pin patterns differ, so a read that comes from the wrong source shows up. A mixed-mode vector gives each pin a different mode, and a write value that sets bit 7, to catch a swapped or shifted mode field. Directed sequences cover the following:
- the reset values;
- the exact synchronizer delay;
- holding of read data between strobes;
- writes made in input mode, then seen in alternate mode;
- writes blocked during manual reset.

// File: rtl/gpio_port_pkg.sv
// Package: shared mode encoding for the GPIO port.
// Assumes two mode bits per pin, packed from bit 0 upward in the mode register.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        PM_ALT     = 2'b00,
        PM_OUT     = 2'b01,
        PM_IN_PU   = 2'b10,
        PM_IN_NOPU = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: multi-stage synchronizer for the pad inputs.
// Assumes the inputs are asynchronous. It is cleared by power-on reset only.
module gpio_pin_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // First stage samples the raw pad level.
    always_ff @(posedge clk) begin
        if (!por_n) st[0] <= '0;
        else        st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage re-times the stage before it.
        always_ff @(posedge clk) begin
            if (!por_n) st[i] <= '0;
            else        st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Module: data latch and mode register storage.
// Assumes bus_sel=0 addresses the data latches and bus_sel=1 the mode fields.
// Power-on reset initializes both registers. Manual reset blocks writes and changes nothing.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 mrst_n,
    input  logic                 wr_en,
    input  logic                 sel,
    input  logic [2*NPINS-1:0]   wdata,
    output logic [NPINS-1:0]     data_q,
    output logic [2*NPINS-1:0]   mode_q
);
    localparam logic [2*NPINS-1:0] MODE_RST = {NPINS{PM_IN_PU}};

    logic wr_ok;
    assign wr_ok = wr_en && mrst_n;

    // Data latch: cleared at power-on, loaded by data writes in any mode.
    always_ff @(posedge clk) begin
        if (!por_n)            data_q <= '0;
        else if (wr_ok && !sel) data_q <= wdata[NPINS-1:0];
    end

    // Mode fields: set to input-with-pull-up at power-on, loaded by mode writes.
    always_ff @(posedge clk) begin
        if (!por_n)           mode_q <= MODE_RST;
        else if (wr_ok && sel) mode_q <= wdata;
    end

    // R8
    mrst_keeps_regs_chk: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> ($stable(data_q) && $stable(mode_q)));

    // R10
    data_write_lands_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !sel && mrst_n) |=> (data_q == $past(wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: per-pin pad control and read-source multiplexer.
// Assumes pin_sync is already synchronized. Purely combinational.
module gpio_pin_ctrl
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic [2*NPINS-1:0] mode_q,
    input  logic [NPINS-1:0]   data_q,
    input  logic [NPINS-1:0]   pin_sync,
    output logic [NPINS-1:0]   pin_oe,
    output logic [NPINS-1:0]   pin_pu,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   rd_bits
);
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        pin_mode_e md;
        assign md = pin_mode_e'(mode_q[2*n +: 2]);

        // Decode the pin's mode into pad controls and the read source.
        always_comb begin
            pin_oe[n]  = 1'b0;
            pin_pu[n]  = 1'b0;
            pin_out[n] = 1'b0;
            rd_bits[n] = data_q[n];
            case (md)
                PM_ALT: ;
                PM_OUT: begin
                    pin_oe[n]  = 1'b1;
                    pin_out[n] = data_q[n];
                end
                PM_IN_PU: begin
                    pin_pu[n]  = 1'b1;
                    rd_bits[n] = pin_sync[n];
                end
                PM_IN_NOPU: rd_bits[n] = pin_sync[n];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mode_port.sv
// Module: top of the seven-pin mode-controlled GPIO port.
// Assumes a single-cycle strobe bus. Read data is registered one cycle after bus_rd.
// Synchronous active-low power-on reset and manual reset.
module gpio_mode_port #(
    parameter int NPINS       = 7,
    parameter int BUS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu
);
    localparam int MODE_W = 2 * NPINS;

    logic [NPINS-1:0]  data_q;
    logic [MODE_W-1:0] mode_q;
    logic [NPINS-1:0]  pin_sync;
    logic [NPINS-1:0]  rd_bits;
    logic [BUS_W-1:0]  rd_next;

    gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_port_regs #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .por_n  (por_n),
        .mrst_n (mrst_n),
        .wr_en  (bus_wr),
        .sel    (bus_sel),
        .wdata  (bus_wdata[MODE_W-1:0]),
        .data_q (data_q),
        .mode_q (mode_q)
    );

    gpio_pin_ctrl #(.NPINS(NPINS)) u_ctrl (
        .mode_q   (mode_q),
        .data_q   (data_q),
        .pin_sync (pin_sync),
        .pin_oe   (pin_oe),
        .pin_pu   (pin_pu),
        .pin_out  (pin_out),
        .rd_bits  (rd_bits)
    );

    // Select the read word and zero-fill the reserved bits.
    always_comb begin
        rd_next = '0;
        if (bus_sel) rd_next[MODE_W-1:0] = mode_q;
        else         rd_next[NPINS-1:0]  = rd_bits;
    end

    // Read register: cleared by either reset, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!por_n || !mrst_n) bus_rdata <= '0;
        else if (bus_rd)       bus_rdata <= rd_next;
    end

    // R2
    data_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && !bus_sel) |=> (bus_rdata[BUS_W-1:NPINS] == '0));

    // R4
    oe_pu_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pin_oe & pin_pu) == '0);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!bus_rd && mrst_n) |=> $stable(bus_rdata));

    // R8
    mrst_clears_rdata_chk: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> (bus_rdata == '0));

    for (genvar n = 0; n < NPINS; n++) begin : g_chk
        // R3
        oe_drives_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
            pin_oe[n] |-> (pin_out[n] == data_q[n]));
        // R3
        out_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
            !pin_oe[n] |-> !pin_out[n]);
    end
endmodule

// File: tb/gpio_mode_port_tb.sv
module gpio_mode_port_tb;
    typedef struct packed {
        logic [15:0] ctrl;
        logic [7:0]  wdat;
        logic [6:0]  pins;
        logic [7:0]  rd;
        logic [6:0]  oe;
        logic [6:0]  pu;
        logic [6:0]  out;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h5A, 7'h0F, 8'h5A, 7'h00, 7'h00, 7'h00},
        '{16'h1555, 8'h33, 7'h7F, 8'h33, 7'h7F, 7'h00, 7'h33},
        '{16'h2AAA, 8'h7F, 7'h15, 8'h15, 7'h00, 7'h7F, 7'h00},
        '{16'h3FFF, 8'h00, 7'h6A, 8'h6A, 7'h00, 7'h00, 7'h00},
        '{16'h24E4, 8'hAA, 7'h55, 8'h66, 7'h22, 7'h44, 7'h22},
        '{16'h1555, 8'h80, 7'h00, 8'h00, 7'h7F, 7'h00, 7'h00}
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [6:0]  pin_in = '0;
    logic [6:0]  pin_out, pin_oe, pin_pu;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_mode_port u_dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic sel);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        por_n = 1'b1;
        // R1 reset state
        rd(1'b1);
        chk("R1", "mode reg after POR", bus_rdata, 16'h2AAA);
        chk("R1", "pu after POR", {9'd0, pin_pu}, 16'h007F);
        chk("R1", "oe after POR", {9'd0, pin_oe}, 16'h0000);
        chk("R1", "out after POR", {9'd0, pin_out}, 16'h0000);
        pin_in = 7'h33; idle(3);
        rd(1'b0);
        chk("R6", "POR input mode reads pins", bus_rdata, 16'h0033);
        wr(1'b1, 16'h0000);
        rd(1'b0);
        chk("R1", "latch cleared by POR", bus_rdata, 16'h0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            pin_in = VECS[i].pins;
            wr(1'b1, VECS[i].ctrl);
            wr(1'b0, {8'h00, VECS[i].wdat});
            idle(3);
            rd(1'b0);
            chk("R5/R6", $sformatf("vec%0d read", i), bus_rdata, {8'h00, VECS[i].rd});
            chk("R3", $sformatf("vec%0d oe", i), {9'd0, pin_oe}, {9'd0, VECS[i].oe});
            chk("R4", $sformatf("vec%0d pu", i), {9'd0, pin_pu}, {9'd0, VECS[i].pu});
            chk("R3", $sformatf("vec%0d out", i), {9'd0, pin_out}, {9'd0, VECS[i].out});
        end

        // R2 reserved mode bits
        wr(1'b1, 16'hFFFF);
        rd(1'b1);
        chk("R2", "mode reserved bits", bus_rdata, 16'h3FFF);

        // R6 synchronizer delay
        wr(1'b1, 16'h2AAA);
        pin_in = 7'h00; idle(3);
        @(negedge clk);
        pin_in = 7'h7F; bus_sel = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        chk("R6", "read at 1st edge", bus_rdata, 16'h0000);
        @(negedge clk);
        chk("R6", "read at 2nd edge", bus_rdata, 16'h0000);
        @(negedge clk);
        chk("R6", "read at 3rd edge", bus_rdata, 16'h007F);
        bus_rd = 1'b0;

        // R9 hold between reads
        pin_in = 7'h00; idle(4);
        chk("R9", "rdata held without strobe", bus_rdata, 16'h007F);

        // R7 write in input mode, seen later in alternate mode
        wr(1'b1, 16'h3FFF);
        pin_in = 7'h11;
        wr(1'b0, 16'h004C);
        idle(2);
        rd(1'b0);
        chk("R7", "input mode reads pin", bus_rdata, 16'h0011);
        chk("R7", "no drive in input mode", {9'd0, pin_out}, 16'h0000);
        wr(1'b1, 16'h0000);
        rd(1'b0);
        chk("R7", "latch written in input mode", bus_rdata, 16'h004C);

        // R10 write then read in the next cycle
        @(negedge clk);
        bus_sel = 1'b0; bus_wdata = 16'h0061; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10", "read right after write", bus_rdata, 16'h0061);

        // R8 manual reset
        wr(1'b1, 16'h1555);
        wr(1'b0, 16'h002D);
        @(negedge clk);
        mrst_n = 1'b0;
        wr(1'b0, 16'h0011);
        wr(1'b1, 16'h0000);
        chk("R8", "rdata cleared in manual reset", bus_rdata, 16'h0000);
        chk("R8", "pads kept in manual reset", {9'd0, pin_out}, 16'h002D);
        @(negedge clk);
        mrst_n = 1'b1;
        rd(1'b0);
        chk("R8", "data kept after manual reset", bus_rdata, 16'h002D);
        chk("R8", "oe kept after manual reset", {9'd0, pin_oe}, 16'h007F);
        rd(1'b1);
        chk("R8", "mode kept after manual reset", bus_rdata, 16'h1555);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule